// File: doc/BRIEF.md
# Byte-Wide Single-Cycle Processor Core

This core executes one 8-bit instruction per clock cycle. It fetches from an instruction store that is separate from data storage. An external byte-addressed data memory with a single port holds operands and results. Inside the core are four general registers, an ALU and a one-bit condition flag. The program counter can branch relative to itself. A stop instruction freezes the core until the next reset.

Every instruction fits in one byte. The leading bits pick the format. Arithmetic, compare and shift instructions may update the flag. A conditional branch reads the flag to choose its next address. Loads and stores go through the single data port. They never touch the flag, so an ALU operation and a memory access never share a cycle. The core has no multiply, no stack and no subroutine call. A host writes a program into the instruction store, releases reset and waits for `halted`.

Top module: `byte_cpu`

## Requirements
- R1: While rst_n is low at a rising clock edge, the core returns the program counter (imem_addr) to 0, clears the condition flag, drops halted, and makes no memory write.
- R2: Encoding 0ooo ddss is a register-register operation: ooo = 000 add, 001 subtract (rd - rs), 010 and, 011 or, 100 xor, 101 copy rs. The result goes to register rd, and no other register changes in that cycle. Codes 110 and 111 write no register.
- R3: The flag is written only by add (carry out), subtract (borrow, set when rd < rs unsigned), 110 compare-less (flag = rd < rs unsigned), 111 compare-equal (flag = rd == rs), and the two shifts. Every other instruction leaves the flag unchanged.
- R4: Encoding 10dd iiii adds the sign-extended 4-bit value iiii to register dd and leaves the flag unchanged.
- R5: Encoding 1110 ddoo operates on register dd: oo = 00 shift left (flag = old bit 7), 01 logical shift right (flag = old bit 0), 10 clear to zero, 11 bitwise invert.
- R6: Encoding 1100 ddaa loads data memory at the address held in register aa into register dd. Encoding 1101 ddaa writes register dd to the address held in register aa. The core raises dmem_we only during a store cycle, and never more than once per instruction.
- R7: A load or a store never changes the condition flag.
- R8: Encoding 1111 oooo with oooo nonzero is a conditional branch. When the flag is 1, the next address is the branch's own address plus sign-extended oooo. When the flag is 0, the next address is the branch's address plus 1.
- R9: Encoding 1111 0000 stops the core. halted rises after the cycle in which it executes. From then until reset, imem_addr holds its value and no memory or register write occurs.
- R10: Each cycle after reset release retires exactly one instruction. The number of cycles before halted rises therefore equals the number of instructions executed, the stop instruction included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 8 | Address of the instruction being executed |
| imem_data | input | 8 | Instruction byte at imem_addr, combinational |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Data to write on a store |
| dmem_rdata | input | 8 | Data read at dmem_addr, combinational |
| dmem_we | output | 1 | Store strobe for the current cycle |
| halted | output | 1 | High once the stop instruction has executed |

## Verification
Three programs drive the core. The first is a counted loop that sums four bytes through a backward branch. Its result and cycle count show that loads, taken backward branches and loop exit all work. The second builds its values from immediates and applies every ALU and unary operation, placing branches where only the correct carry, borrow or unchanged flag picks the path that stores the expected byte. This program tells apart flag-writing instructions from flag-preserving ones. The third sets the flag, then runs a load and a store before a branch, so a flag clobbered by a memory access would halt the core early with a short store sequence. Each program is also interrupted by a mid-run reset, which confirms that the program counter restarts at zero and that the halted state clears.

// File: rtl/byte_cpu_pkg.sv
`timescale 1ns/1ps
// Shared widths, ALU operation codes and the decoded control bundle.
// Assumes the fixed one-byte instruction format described in the brief.
package byte_cpu_pkg;
    localparam int WORD_W    = 8;
    localparam int REG_CNT   = 4;
    localparam int REG_SEL_W = $clog2(REG_CNT);
    localparam int IMM_W     = 4;

    // The first eight codes follow the register-register opcode field order.
    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_PASS, OP_LT, OP_EQ,
        OP_SHL, OP_SHR, OP_ZERO, OP_INV
    } alu_op_e;

    typedef struct packed {
        alu_op_e               op;
        logic [REG_SEL_W-1:0]  rd;
        logic [REG_SEL_W-1:0]  rs;
        logic                  use_imm;
        logic [WORD_W-1:0]     imm;
        logic                  reg_we;
        logic                  flag_we;
        logic                  mem_we;
        logic                  from_mem;
        logic                  branch;
        logic                  halt;
    } ctrl_t;
endpackage

// File: rtl/byte_cpu_decode.sv
`timescale 1ns/1ps
// Instruction decoder: turns one instruction byte into control signals.
// Purely combinational; assumes the byte is valid for the whole cycle.
module byte_cpu_decode
    import byte_cpu_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output ctrl_t             ctrl
);
    // Decode the format from the leading bits, then the operation.
    always_comb begin
        ctrl     = '0;
        ctrl.rd  = instr[3:2];
        ctrl.rs  = instr[1:0];
        ctrl.imm = {{(WORD_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
        if (!instr[7]) begin
            ctrl.op      = alu_op_e'({1'b0, instr[6:4]});
            ctrl.reg_we  = (instr[6:5] != 2'b11);
            ctrl.flag_we = (instr[6:5] == 2'b11) || (instr[6:5] == 2'b00);
        end else if (!instr[6]) begin
            ctrl.rd      = instr[5:4];
            ctrl.op      = OP_ADD;
            ctrl.use_imm = 1'b1;
            ctrl.reg_we  = 1'b1;
        end else begin
            case (instr[5:4])
                2'b00: begin
                    ctrl.reg_we   = 1'b1;
                    ctrl.from_mem = 1'b1;
                end
                2'b01: ctrl.mem_we = 1'b1;
                2'b10: begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.flag_we = !instr[1];
                    case (instr[1:0])
                        2'b00:   ctrl.op = OP_SHL;
                        2'b01:   ctrl.op = OP_SHR;
                        2'b10:   ctrl.op = OP_ZERO;
                        default: ctrl.op = OP_INV;
                    endcase
                end
                default: begin
                    if (instr[IMM_W-1:0] == '0) ctrl.halt   = 1'b1;
                    else                        ctrl.branch = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/byte_cpu_alu.sv
`timescale 1ns/1ps
// ALU: arithmetic, logic, compares and single-bit shifts.
// Produces a result and a candidate flag; the caller decides what is kept.
module byte_cpu_alu
    import byte_cpu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         flag_out
);
    logic [W:0] sum;
    logic [W:0] diff;

    // Widened add and subtract expose the carry and the borrow.
    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
    end

    // Select the result and the flag candidate for the operation.
    always_comb begin
        y        = '0;
        flag_out = 1'b0;
        case (op)
            OP_ADD:  begin y = sum[W-1:0];  flag_out = sum[W];  end
            OP_SUB:  begin y = diff[W-1:0]; flag_out = diff[W]; end
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_PASS: y = b;
            OP_LT:   flag_out = diff[W];
            OP_EQ:   flag_out = (a == b);
            OP_SHL:  begin y = {a[W-2:0], 1'b0}; flag_out = a[W-1]; end
            OP_SHR:  begin y = {1'b0, a[W-1:1]}; flag_out = a[0];   end
            OP_ZERO: y = '0;
            OP_INV:  y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/byte_cpu_regfile.sv
`timescale 1ns/1ps
// Register file: N words of W bits, two read ports and one write port.
// Contents are not reset; programs must write a register before reading it.
module byte_cpu_regfile #(
    parameter int W  = 8,
    parameter int N  = 4,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] raddr_a,
    input  logic [SW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [N-1:0]  wr_sel
);
    logic [W-1:0] bank [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        logic [W-1:0] q;
        assign wr_sel[g] = we && (waddr == SW'(g));
        // Capture write data when this word is selected.
        always_ff @(posedge clk) begin
            if (wr_sel[g]) q <= wdata;
        end
        assign bank[g] = q;
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];
endmodule

// File: rtl/byte_cpu_fetch.sv
`timescale 1ns/1ps
// Fetch unit: program counter, relative branching and the stop latch.
// Assumes the offset is already sign-extended to the counter width.
module byte_cpu_fetch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         branch,
    input  logic         halt,
    input  logic         flag,
    input  logic [W-1:0] offset,
    output logic [W-1:0] pc,
    output logic         halted
);
    logic [W-1:0] next_pc;

    // Pick the relative target on a taken branch, else the next address.
    always_comb begin
        next_pc = (branch && flag) ? pc + offset : pc + W'(1);
    end

    // Advance the counter each cycle until the stop instruction runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (halt) halted <= 1'b1;
            else      pc     <= next_pc;
        end
    end
endmodule

// File: rtl/byte_cpu.sv
`timescale 1ns/1ps
// Top level: one instruction per cycle over separate instruction and data
// memories. Assumes both memories answer combinationally within the cycle.
module byte_cpu
    import byte_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_data,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic              dmem_we,
    output logic              halted
);
    ctrl_t              ctrl;
    logic               exec;
    logic               halted_q;
    logic               flag_q;
    logic [WORD_W-1:0]  pc;
    logic [WORD_W-1:0]  ra_val;
    logic [WORD_W-1:0]  rb_val;
    logic [WORD_W-1:0]  alu_b;
    logic [WORD_W-1:0]  alu_y;
    logic               alu_flag;
    logic [WORD_W-1:0]  wb_data;
    logic [REG_CNT-1:0] wr_sel;
    logic               mem_op_c;
    logic               br_c;
    logic               halt_c;

    assign exec     = rst_n && !halted_q;
    assign alu_b    = ctrl.use_imm ? ctrl.imm : rb_val;
    assign wb_data  = ctrl.from_mem ? dmem_rdata : alu_y;
    assign mem_op_c = ctrl.mem_we || ctrl.from_mem;
    assign br_c     = ctrl.branch;
    assign halt_c   = ctrl.halt;

    byte_cpu_decode u_dec (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    byte_cpu_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
        .clk     (clk),
        .we      (exec && ctrl.reg_we),
        .waddr   (ctrl.rd),
        .wdata   (wb_data),
        .raddr_a (ctrl.rd),
        .raddr_b (ctrl.rs),
        .rdata_a (ra_val),
        .rdata_b (rb_val),
        .wr_sel  (wr_sel)
    );

    byte_cpu_alu #(.W(WORD_W)) u_alu (
        .a        (ra_val),
        .b        (alu_b),
        .op       (ctrl.op),
        .y        (alu_y),
        .flag_out (alu_flag)
    );

    byte_cpu_fetch #(.W(WORD_W)) u_fetch (
        .clk    (clk),
        .rst_n  (rst_n),
        .branch (ctrl.branch),
        .halt   (ctrl.halt),
        .flag   (flag_q),
        .offset (ctrl.imm),
        .pc     (pc),
        .halted (halted_q)
    );

    // Keep the condition flag; only flag-writing instructions update it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (exec && ctrl.flag_we)  flag_q <= alu_flag;
    end

    assign imem_addr  = pc;
    assign dmem_addr  = rb_val;
    assign dmem_wdata = ra_val;
    assign dmem_we    = exec && ctrl.mem_we;
    assign halted     = halted_q;
endmodule

// File: rtl/byte_cpu_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the core, bound into byte_cpu.
// Observes ports plus the flag, decode summaries and register write selects.
module byte_cpu_chk #(
    parameter int W = 8,
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] imem_addr,
    input logic         halted,
    input logic         dmem_we,
    input logic         flag_q,
    input logic         mem_op_c,
    input logic         br_c,
    input logic         halt_c,
    input logic [N-1:0] wr_sel
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == '0 && !halted && !flag_q));

    // R2
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R6
    no_store_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we);

    // R7
    mem_flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op_c && !halted) |=> $stable(flag_q));

    // R8
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !br_c && !halt_c) |=> (imem_addr == W'($past(imem_addr) + 1'b1)));

    // R9
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_c && !halted) |=> halted);

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));
endmodule

bind byte_cpu byte_cpu_chk #(.W(byte_cpu_pkg::WORD_W), .N(byte_cpu_pkg::REG_CNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .halted    (halted),
    .dmem_we   (dmem_we),
    .flag_q    (flag_q),
    .mem_op_c  (mem_op_c),
    .br_c      (br_c),
    .halt_c    (halt_c),
    .wr_sel    (wr_sel)
);

// File: tb/byte_cpu_test.sv
`timescale 1ns/1ps
// Scoreboard bench: each program's expected stores are queued by a driver
// task, and a monitor pops and compares them as the core writes memory.
module byte_cpu_test;
    import byte_cpu_pkg::*;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [WORD_W-1:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic              dmem_we, halted;
    logic [WORD_W-1:0] imem [256];
    logic [WORD_W-1:0] dmem [256];
    logic [WORD_W-1:0] prog [$];

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    // Data memory model: one write per cycle on the store strobe.
    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    byte_cpu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .halted     (halted)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      req;
    } exp_t;
    exp_t sb [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_store(input logic [7:0] a, input logic [7:0] d, input string req);
        exp_t e;
        e.a = a; e.d = d; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare every store against the head of the scoreboard.
    always @(negedge clk) begin
        exp_t e;
        if (dmem_we) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected store at", dmem_addr, 0);
            end else begin
                e = sb.pop_front();
                check(dmem_addr == e.a, e.req, "store address", dmem_addr, e.a);
                check(dmem_wdata == e.d, e.req, "store data", dmem_wdata, e.d);
            end
        end
    end

    task automatic load_prog();
        for (int i = 0; i < 256; i++) imem[i] = 8'hF0;
        for (int i = 0; i < prog.size(); i++) imem[i] = prog[i];
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(imem_addr == 8'h00, "R1", "pc in reset", imem_addr, 0);
        check(halted == 1'b0, "R1", "halted in reset", halted, 0);
        check(dmem_we == 1'b0, "R1", "store strobe in reset", dmem_we, 0);
    endtask

    // Interrupt a run after a few cycles, then restart it from reset.
    task automatic partial_then_reset(input int steps);
        hold_reset();
        rst_n = 1'b1;
        repeat (steps) @(negedge clk);
        check(imem_addr == steps[7:0], "R10", "pc after straight-line cycles", imem_addr, steps);
        rst_n = 1'b0;
        @(negedge clk);
        check(imem_addr == 8'h00 && !halted, "R1", "pc after mid-run reset", imem_addr, 0);
    endtask

    task automatic run_prog(input int exp_cycles);
        int n = 0;
        logic [7:0] stop_pc;
        hold_reset();
        rst_n = 1'b1;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted || n >= 2000) break;
        end
        check(n == exp_cycles, "R10", "cycles to halt", n, exp_cycles);
        check(sb.size() == 0, "R6", "stores still pending", sb.size(), 0);
        stop_pc = imem_addr;
        repeat (5) @(negedge clk);
        check(halted && imem_addr == stop_pc, "R9", "pc while stopped", imem_addr, stop_pc);
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;

        // Program A: loop summing four bytes with a backward branch (R8).
        dmem[0] = 8'h0A; dmem[1] = 8'h14; dmem[2] = 8'h1E; dmem[3] = 8'h28;
        prog = '{8'hE2, 8'hE6, 8'hEA, 8'hA4, 8'hCD, 8'h03, 8'h91, 8'h66,
                 8'hFC, 8'hD2, 8'hA1, 8'hD6, 8'hF0};
        load_prog();
        partial_then_reset(3);
        expect_store(8'h04, 8'h64, "R8");
        expect_store(8'h05, 8'h04, "R6");
        run_prog(28);
        check(dmem[4] == 8'h64, "R6", "memory word 4", dmem[4], 8'h64);

        // Program B: every ALU and unary operation with flag-steered branches.
        prog = '{8'hE2, 8'h88, 8'hE6, 8'h97, 8'h58, 8'h09, 8'hF2, 8'hEE,
                 8'hDB, 8'h09, 8'hF2, 8'hD3, 8'hB1, 8'hDB, 8'h19, 8'h48,
                 8'hF2, 8'hEA, 8'hB1, 8'hDB, 8'hE0, 8'hE5, 8'h31, 8'hE7,
                 8'h24, 8'hB1, 8'hD3, 8'hB1, 8'hD7, 8'h71, 8'hF2, 8'hB1,
                 8'hDF, 8'hF0};
        load_prog();
        expect_store(8'h00, 8'hFF, "R2");
        expect_store(8'h01, 8'h06, "R8");
        expect_store(8'h02, 8'h07, "R3");
        expect_store(8'h03, 8'hF3, "R5");
        expect_store(8'h04, 8'hF0, "R5");
        expect_store(8'h05, 8'h05, "R4");
        run_prog(32);

        // Program C: flag set, then load and store, then a flag-tested branch.
        dmem[0] = 8'h5A;
        prog = '{8'hE2, 8'h70, 8'hC4, 8'hD0, 8'hF2, 8'hF0, 8'h81, 8'hD4, 8'hF0};
        load_prog();
        expect_store(8'h00, 8'h00, "R6");
        expect_store(8'h01, 8'h5A, "R7");
        run_prog(8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule